// File: doc/BRIEF.md
# Wide Memory Behind a 16-Bit Register Bus

This block is a dual-port RAM whose words can be wider than 16 bits. One port faces a 16-bit register bus. The other port faces user logic and carries full words. Bus hosts cannot reach a wide word in one access, so each word is cut into 16-bit pieces called slices. Slice 0 holds the least significant bits. Each slice has its own window of bus addresses, one address per entry, and the windows are stacked one after another from a base address. Reading or writing one bus address touches exactly one slice of one entry.

The user port addresses whole entries. It writes a full word under a write enable, and it returns the stored word one clock after the address is presented. Both ports share one storage array, so a value written from either side can be read from the other. Word width, entry count and base address are parameters.

On the bus port, every request produces a response two cycles later. A request to an address outside the window is passed through unchanged, and its response is flagged as not claimed, so several such blocks can sit in a chain on the same bus.

Top module: `wide_mem_bus16`

## Requirements
- R1: After reset, every bus address in the window reads 0, every user entry reads 0, and `rsp_valid` is low.
- R2: Slice k of entry i sits at bus address BASE + k*DEPTH + i. Slice k holds word bits [16k+15:16k], so slice 0 carries the least significant bits.
- R3: When WIDTH is not a multiple of 16, the last slice holds only WIDTH mod 16 bits. Its higher bus data bits are dropped on write and read back as 0.
- R4: The window runs from BASE through BASE + ceil(WIDTH/16)*DEPTH - 1, both ends included. A request outside it gets `rsp_hit`=0, echoes the request data, and changes no entry.
- R5: A request presented in cycle c gets its response in cycle c+2. The response has `rsp_valid`=1 and repeats the request's write flag and address. A claimed read returns the addressed slice. A write returns its own write data.
- R6: With `user_we` low, `user_rdata` shows the entry at `user_addr` one cycle after the address is presented.
- R7: A word written from the user port can be read as slices from the bus. Slices written from the bus can be read as a word from the user port.
- R8: A bus write to one slice leaves every other slice of that entry unchanged.
- R9: If the bus and the user port write the same entry in the same cycle, the user port's word is stored in full. If they write different entries in the same cycle, both writes take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all entries |
| req_valid | input | 1 | A bus request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Bus address |
| req_wdata | input | 16 | Bus write data; passed through on unclaimed requests |
| rsp_valid | output | 1 | Response present, two cycles after the request |
| rsp_write | output | 1 | Write flag of the answered request |
| rsp_addr | output | 16 | Address of the answered request |
| rsp_data | output | 16 | Read slice, or the echoed request data |
| rsp_hit | output | 1 | 1 when the address fell inside this block's window |
| user_addr | input | $clog2(DEPTH) | User entry index |
| user_wdata | input | WIDTH | User write word |
| user_we | input | 1 | User write enable |
| user_rdata | output | WIDTH | Entry at the previous cycle's `user_addr` |

## Verification
A bus request driven before rising edge n is registered at edge n. Its response is registered at edge n+1, and the bench samples it on the falling edge that follows. The checker uses a post-reset cycle counter to compare the response against the request from exactly two edges earlier.

Writes from either port land at the same edge that samples them. So a bus read issued in the next cycle, or a user read whose address is presented in the next cycle, already sees the new data. The bench waits for those edges before it compares against its reference model.

// File: rtl/wmb_pkg.sv
package wmb_pkg;
    localparam int unsigned BUS_W = 16;

    typedef struct packed {
        logic             valid;
        logic             write;
        logic             hit;
        logic [BUS_W-1:0] addr;
        logic [BUS_W-1:0] data;
    } bus_beat_t;

    function automatic int unsigned slices_for(input int unsigned width);
        return (width + BUS_W - 1) / BUS_W;
    endfunction

    function automatic int unsigned slice_bits(input int unsigned width, input int unsigned k);
        int unsigned rem;
        rem = width - k * BUS_W;
        return (rem > BUS_W) ? BUS_W : rem;
    endfunction
endpackage

// File: rtl/wmb_addr_decode.sv
module wmb_addr_decode
    import wmb_pkg::*;
#(
    parameter int unsigned WIDTH = 23,
    parameter int unsigned DEPTH = 64,
    parameter int unsigned BASE  = 32'h100,
    parameter int unsigned SEL_W = 1,
    parameter int unsigned ENT_W = 6
) (
    input  logic [BUS_W-1:0] addr,
    output logic             hit,
    output logic [SEL_W-1:0] slice,
    output logic [ENT_W-1:0] entry
);
    localparam int unsigned NSL  = slices_for(WIDTH);
    localparam int unsigned SPAN = NSL * DEPTH;

    logic [31:0] offset;

    always_comb begin
        offset = 32'(addr) - BASE;
        hit    = (32'(addr) >= BASE) && (offset < SPAN);
        slice  = SEL_W'(offset / DEPTH);
        entry  = ENT_W'(offset % DEPTH);
    end
endmodule

// File: rtl/wmb_slice_write.sv
module wmb_slice_write
    import wmb_pkg::*;
#(
    parameter int unsigned WIDTH = 23,
    parameter int unsigned SEL_W = 1
) (
    input  logic [WIDTH-1:0] old_word,
    input  logic [SEL_W-1:0] slice,
    input  logic [BUS_W-1:0] wdata,
    output logic [WIDTH-1:0] new_word
);
    localparam int unsigned NSL = slices_for(WIDTH);

    for (genvar k = 0; k < NSL; k++) begin : g_slice
        localparam int unsigned LO = k * BUS_W;
        localparam int unsigned SW = slice_bits(WIDTH, k);
        assign new_word[LO +: SW] = (slice == SEL_W'(k)) ? wdata[SW-1:0] : old_word[LO +: SW];
    end
endmodule

// File: rtl/wmb_slice_read.sv
module wmb_slice_read
    import wmb_pkg::*;
#(
    parameter int unsigned WIDTH = 23,
    parameter int unsigned SEL_W = 1
) (
    input  logic [WIDTH-1:0] word,
    input  logic [SEL_W-1:0] slice,
    output logic [BUS_W-1:0] rdata
);
    localparam int unsigned NSL = slices_for(WIDTH);

    logic [BUS_W-1:0] padded [NSL];

    for (genvar k = 0; k < NSL; k++) begin : g_slice
        localparam int unsigned LO = k * BUS_W;
        localparam int unsigned SW = slice_bits(WIDTH, k);
        logic [BUS_W-1:0] pad;
        always_comb begin
            pad         = '0;
            pad[SW-1:0] = word[LO +: SW];
        end
        assign padded[k] = pad;
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NSL; k++) begin
            if (slice == SEL_W'(k)) rdata = padded[k];
        end
    end
endmodule

// File: rtl/wide_mem_bus16.sv
module wide_mem_bus16
    import wmb_pkg::*;
#(
    parameter int unsigned WIDTH = 23,
    parameter int unsigned DEPTH = 64,
    parameter int unsigned BASE  = 32'h100,
    localparam int unsigned NSL   = slices_for(WIDTH),
    localparam int unsigned SEL_W = (NSL > 1) ? $clog2(NSL) : 1,
    localparam int unsigned ENT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [15:0]      req_addr,
    input  logic [15:0]      req_wdata,
    output logic             rsp_valid,
    output logic             rsp_write,
    output logic [15:0]      rsp_addr,
    output logic [15:0]      rsp_data,
    output logic             rsp_hit,
    input  logic [ENT_W-1:0] user_addr,
    input  logic [WIDTH-1:0] user_wdata,
    input  logic             user_we,
    output logic [WIDTH-1:0] user_rdata
);
    typedef struct packed {
        bus_beat_t        s1;
        logic [SEL_W-1:0] s1_slice;
        logic [ENT_W-1:0] s1_entry;
        bus_beat_t        s2;
        logic [WIDTH-1:0] urd;
    } pipe_t;

    pipe_t            pipe_d, pipe_q;
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    logic             dec_hit;
    logic [SEL_W-1:0] dec_slice;
    logic [ENT_W-1:0] dec_entry;
    logic [WIDTH-1:0] merged_word;
    logic [BUS_W-1:0] read_slice;

    wmb_addr_decode #(
        .WIDTH(WIDTH), .DEPTH(DEPTH), .BASE(BASE), .SEL_W(SEL_W), .ENT_W(ENT_W)
    ) u_dec (
        .addr  (req_addr),
        .hit   (dec_hit),
        .slice (dec_slice),
        .entry (dec_entry)
    );

    wmb_slice_write #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_wr (
        .old_word (mem_q[dec_entry]),
        .slice    (dec_slice),
        .wdata    (req_wdata),
        .new_word (merged_word)
    );

    wmb_slice_read #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_rd (
        .word  (mem_q[pipe_q.s1_entry]),
        .slice (pipe_q.s1_slice),
        .rdata (read_slice)
    );

    always_comb begin
        pipe_d = pipe_q;
        mem_d  = mem_q;

        // request stage
        pipe_d.s1.valid  = req_valid;
        pipe_d.s1.write  = req_write;
        pipe_d.s1.hit    = dec_hit;
        pipe_d.s1.addr   = req_addr;
        pipe_d.s1.data   = req_wdata;
        pipe_d.s1_slice  = dec_slice;
        pipe_d.s1_entry  = dec_entry;

        // bus write first, user write after so it wins on a shared entry
        if (req_valid && req_write && dec_hit) begin
            mem_d[dec_entry] = merged_word;
        end
        if (user_we && (32'(user_addr) < DEPTH)) begin
            mem_d[user_addr] = user_wdata;
        end

        // response stage
        pipe_d.s2 = pipe_q.s1;
        if (pipe_q.s1.valid && !pipe_q.s1.write && pipe_q.s1.hit) begin
            pipe_d.s2.data = read_slice;
        end

        // user read path
        pipe_d.urd = (32'(user_addr) < DEPTH) ? mem_q[user_addr] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            pipe_q <= pipe_d;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rsp_valid  = pipe_q.s2.valid;
    assign rsp_write  = pipe_q.s2.write;
    assign rsp_addr   = pipe_q.s2.addr;
    assign rsp_data   = pipe_q.s2.data;
    assign rsp_hit    = pipe_q.s2.hit;
    assign user_rdata = pipe_q.urd;
endmodule

// File: rtl/wmb_checker.sv
module wmb_checker #(
    parameter int unsigned WIDTH = 23,
    parameter int unsigned DEPTH = 64,
    parameter int unsigned BASE  = 32'h100
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [15:0] req_addr,
    input logic [15:0] req_wdata,
    input logic        rsp_valid,
    input logic        rsp_write,
    input logic [15:0] rsp_addr,
    input logic [15:0] rsp_data,
    input logic        rsp_hit
);
    localparam int unsigned NSL     = (WIDTH + 15) / 16;
    localparam int unsigned TOP     = BASE + NSL * DEPTH - 1;
    localparam int unsigned REM     = WIDTH % 16;
    localparam int unsigned LAST_LO = BASE + (NSL - 1) * DEPTH;

    logic [1:0] cyc_q;
    always_ff @(posedge clk) begin
        if (!rst_n) cyc_q <= '0;
        else if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
    end

    // R5
    rsp_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd2) |-> (rsp_valid == $past(req_valid, 2)));

    // R5
    rsp_addr_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd2 && rsp_valid) |-> (rsp_addr == $past(req_addr, 2)));

    // R4
    unclaimed_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd2 && rsp_valid && !rsp_hit) |-> (rsp_data == $past(req_wdata, 2)));

    // R4
    window_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit == ((32'(rsp_addr) >= BASE) && (32'(rsp_addr) <= TOP))));

    if (REM != 0) begin : g_narrow
        // R3
        last_slice_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid && rsp_hit && !rsp_write && (32'(rsp_addr) >= LAST_LO))
                |-> ((rsp_data >> REM) == 16'd0));
    end
endmodule

bind wide_mem_bus16 wmb_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH), .BASE(BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_write (rsp_write),
    .rsp_addr  (rsp_addr),
    .rsp_data  (rsp_data),
    .rsp_hit   (rsp_hit)
);

// File: tb/tb_wide_mem_bus16.sv
module tb_wide_mem_bus16;
    localparam int unsigned W     = 23;
    localparam int unsigned D     = 64;
    localparam int unsigned BASE  = 32'h100;
    localparam int unsigned NSL   = (W + 15) / 16;
    localparam int unsigned NADDR = NSL * D;
    localparam int unsigned EW    = $clog2(D);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [15:0]   req_addr = '0, req_wdata = '0;
    logic          rsp_valid, rsp_write, rsp_hit;
    logic [15:0]   rsp_addr, rsp_data;
    logic [EW-1:0] user_addr = '0;
    logic [W-1:0]  user_wdata = '0;
    logic          user_we = 1'b0;
    logic [W-1:0]  user_rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic [W-1:0] model [D];

    always #4 clk = ~clk;

    wide_mem_bus16 #(.WIDTH(W), .DEPTH(D), .BASE(BASE)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
        .rsp_hit(rsp_hit),
        .user_addr(user_addr), .user_wdata(user_wdata), .user_we(user_we), .user_rdata(user_rdata)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [15:0] data;
        logic        hit;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h0105, 16'hBEEF, 1'b1, 16'hBEEF},
        '{1'b0, 16'h0105, 16'h0000, 1'b1, 16'hBEEF},
        '{1'b1, 16'h0145, 16'hFFFF, 1'b1, 16'hFFFF},
        '{1'b0, 16'h0145, 16'h0000, 1'b1, 16'h007F},
        '{1'b0, 16'h0105, 16'h0000, 1'b1, 16'hBEEF},
        '{1'b0, 16'h00FF, 16'h1234, 1'b0, 16'h1234},
        '{1'b0, 16'h0180, 16'hA5A5, 1'b0, 16'hA5A5},
        '{1'b0, 16'h017F, 16'h0000, 1'b1, 16'h0000},
        '{1'b1, 16'h0180, 16'h5555, 1'b0, 16'h5555},
        '{1'b0, 16'h0100, 16'h0000, 1'b1, 16'h0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] addr_of(input int idx);
        return 16'(BASE + idx);
    endfunction

    function automatic logic [15:0] model_slice(input int idx);
        logic [W-1:0] word;
        word = model[idx % D];
        return 16'(word >> (16 * (idx / D)));
    endfunction

    task automatic model_write(input int idx, input logic [15:0] d);
        for (int b = 0; b < 16; b++) begin
            if ((idx / D) * 16 + b < W) model[idx % D][(idx / D) * 16 + b] = d[b];
        end
    endtask

    task automatic bus_op(input logic wr, input logic [15:0] a, input logic [15:0] d,
                          input logic uwe, input int ua, input logic [W-1:0] ud,
                          output logic hit, output logic [15:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        user_we = uwe; user_addr = EW'(ua); user_wdata = ud;
        @(negedge clk);
        req_valid = 1'b0; user_we = 1'b0;
        @(negedge clk);
        chk("R5 rsp_valid", 32'(rsp_valid), 32'd1);
        chk("R5 rsp_write", 32'(rsp_write), 32'(wr));
        chk("R5 rsp_addr", 32'(rsp_addr), 32'(a));
        hit = rsp_hit;
        rd  = rsp_data;
    endtask

    task automatic bus_read_chk(input string tag, input int idx);
        logic h; logic [15:0] r;
        bus_op(1'b0, addr_of(idx), 16'h0, 1'b0, 0, '0, h, r);
        chk(tag, 32'(r), 32'(model_slice(idx)));
    endtask

    task automatic bus_write(input int idx, input logic [15:0] d);
        logic h; logic [15:0] r;
        bus_op(1'b1, addr_of(idx), d, 1'b0, 0, '0, h, r);
        chk("R5 write echo", 32'(r), 32'(d));
        model_write(idx, d);
    endtask

    task automatic user_read(input int ua, output logic [W-1:0] rd);
        @(negedge clk);
        user_addr = EW'(ua); user_we = 1'b0;
        @(negedge clk);
        rd = user_rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic h; logic [15:0] r; logic [W-1:0] u;
        for (int i = 0; i < D; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state on both sides
        chk("R1 rsp_valid low", 32'(rsp_valid), 32'd0);
        for (int i = 0; i < NADDR; i++) bus_read_chk("R1 bus zero", i);
        for (int i = 0; i < D; i++) begin
            user_read(i, u);
            chk("R1 user zero", 32'(u), 32'd0);
        end

        // vector table: mapping, narrow slice, window edges, pass-through
        for (int v = 0; v < NV; v++) begin
            bus_op(VECS[v].wr, VECS[v].addr, VECS[v].data, 1'b0, 0, '0, h, r);
            chk("R4 rsp_hit vs window", 32'(h), 32'(VECS[v].hit));
            chk("R2 R3 R8 table data", 32'(r), 32'(VECS[v].exp));
        end
        model[5] = {7'h7F, 16'hBEEF};

        // R2: slice 0 is the low half of the word seen from the user side
        user_read(5, u);
        chk("R2 R7 user sees bus slices", 32'(u), 32'(model[5]));

        // R7: user write visible on bus
        @(negedge clk);
        user_we = 1'b1; user_addr = EW'(9); user_wdata = 23'h2A1234;
        @(negedge clk);
        user_we = 1'b0;
        model[9] = 23'h2A1234;
        bus_read_chk("R7 user to bus slice0", 9);
        bus_read_chk("R7 user to bus slice1", D + 9);

        // R6: user read latency one cycle
        user_read(9, u);
        chk("R6 user read", 32'(u), 32'h2A1234);

        // R9: same-entry collision, user wins
        bus_op(1'b1, addr_of(10), 16'h1111, 1'b1, 10, 23'h333333, h, r);
        model[10] = 23'h333333;
        bus_read_chk("R9 collision slice0", 10);
        bus_read_chk("R9 collision slice1", D + 10);
        user_read(10, u);
        chk("R9 collision user", 32'(u), 32'h333333);

        // R9: different entries in the same cycle both land
        bus_op(1'b1, addr_of(D + 11), 16'h0055, 1'b1, 12, 23'h0ABCDE, h, r);
        model_write(D + 11, 16'h0055);
        model[12] = 23'h0ABCDE;
        bus_read_chk("R9 split bus part", D + 11);
        user_read(12, u);
        chk("R9 split user part", 32'(u), 32'h0ABCDE);

        // R8: writing slice 1 keeps slice 0
        bus_write(20, 16'hCAFE);
        bus_write(D + 20, 16'h0011);
        bus_read_chk("R8 other slice kept", 20);

        // write then read every address
        for (int i = 0; i < NADDR; i++) begin
            bus_write(i, 16'($urandom));
            bus_read_chk("R2 write-read", i);
        end

        // shuffled writes, shuffled reads
        for (int j = 0; j < NADDR; j++) bus_write((j * 37 + 5) % NADDR, 16'($urandom));
        for (int j = 0; j < NADDR; j++) bus_read_chk("R2 R3 shuffled read", (j * 53 + 7) % NADDR);

        // random mixed rounds
        for (int rnd = 0; rnd < 5; rnd++) begin
            for (int j = 0; j < NADDR; j++) begin
                if ($urandom % 2 == 0) bus_read_chk("R8 mixed read", (j * 37 + rnd * 11) % NADDR);
                else bus_write((j * 37 + rnd * 11) % NADDR, 16'($urandom));
            end
        end

        // R7: final word compare on the user side
        for (int i = 0; i < D; i += 7) begin
            user_read(i, u);
            chk("R7 user agrees with model", 32'(u), 32'(model[i]));
        end

        // R1: reset again clears contents
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < D; i++) model[i] = '0;
        bus_read_chk("R1 cleared slice0", 20);
        bus_read_chk("R1 cleared slice1", D + 9);
        user_read(12, u);
        chk("R1 cleared user", 32'(u), 32'd0);

        finish_run();
    end
endmodule